// File: doc/BRIEF.md
# Transmit-Pending Flag Register with Atomic Word-Pair Access

This block holds one pending flag per mailbox of a 32-mailbox message controller. The transmit scheduler sees all flags at once on a parallel output. Software reaches the register over a 16-bit peripheral bus at two word addresses: the upper word carries mailboxes 31 down to 16, and the lower word carries mailboxes 15 down to 0. Software can only set flags. A flag drops only when the cancel-request vector or the transmit-done vector pulses on its bit. Mailbox 0 never owns a flag.

A 32-bit access is built from two word accesses, upper word first. A single shadow word makes that pair atomic in both directions:

- **Write:** the upper-word write is parked in the shadow word. The lower-word write then commits both halves in one clock.
- **Read:** the upper-word read returns the live upper half and, in the same clock, freezes the live lower half into the shadow word. The lower-word read that follows returns that frozen copy, so the 32-bit value read back is coherent.

Set requests for mailboxes whose transmit-enable input is low are dropped.

Top module: `txpend_wordbus`

## Requirements
- R1: After reset `pending`, `bus_rdata` and the shadow word are all zero, so a lower-word read issued straight after reset returns 0.
- R2: A write to the upper-word address (0x20) changes no flag; its data is only held in the shadow word.
- R3: A write to the lower-word address (0x22) sets, in one clock, every flag whose bit is 1 in the 32-bit word {shadow, write data}. The shadow word lands in bits 31:16 and the bus data in bits 15:0.
- R4: A written 0 leaves its flag unchanged, and no bus access ever clears a flag.
- R5: A 1 on bit i of `cancel_req` or of `tx_done` clears flag i at the next clock edge.
- R6: When a set and a clear (cancel or done) hit the same bit in the same cycle, the clear wins and the flag ends at 0.
- R7: Bit 0 of `pending` always reads 0, and writes to it are ignored.
- R8: A set bit for a mailbox whose `tx_enable` bit is 0 is ignored.
- R9: A read of the upper-word address (0x20) puts the live `pending[31:16]` on `bus_rdata` one cycle later. In the same clock it copies the live `pending[15:0]` into the shadow word.
- R10: A read of the lower-word address (0x22) puts the shadow word, not the live lower half, on `bus_rdata` one cycle later. Between reads `bus_rdata` holds its last value.
- R11: Any other address is ignored. When `bus_wr` and `bus_rd` are high together, only the write takes effect and `bus_rdata` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears all state |
| bus_addr | input | 8 | Word address on the peripheral bus |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data, valid the cycle after a read |
| tx_enable | input | 32 | Per-mailbox "configured for transmit" qualifier |
| cancel_req | input | 32 | Per-mailbox cancel pulses that clear flags |
| tx_done | input | 32 | Per-mailbox completion pulses that clear flags |
| pending | output | 32 | Pending flags to the transmit scheduler |

## Verification
The bench builds the block with its default parameters: a 16-bit bus word, 8-bit addresses, and the halves at 0x20 and 0x22. With those values every flag is reachable, including the permanently empty bit 0 and the seam between bits 15 and 16. A stray address, 0x24, is also in range.

A behavioural reference model runs beside the block, and its flags and read data are compared every cycle. The directed stimulus interleaves cancellations between the two halves of a read, so a stale or live lower half becomes visible on `bus_rdata`. A pseudo-random phase then mixes writes, reads, stray addresses and sparse clear pulses under a partial enable mask.

// File: rtl/txpend_pkg.sv
package txpend_pkg;

    // Decoded bus operation for one cycle; at most one field is set.
    typedef struct packed {
        logic wr_hi;
        logic wr_lo;
        logic rd_hi;
        logic rd_lo;
    } bus_op_t;

endpackage

// File: rtl/txpend_decode.sv
module txpend_decode
    import txpend_pkg::*;
#(
    parameter int                ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] HI_ADDR = 8'h20,
    parameter logic [ADDR_W-1:0] LO_ADDR = 8'h22
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    output bus_op_t           op
);

    logic hit_hi;
    logic hit_lo;

    // A write strobe masks a read strobe issued in the same cycle.
    always_comb begin
        hit_hi   = (addr == HI_ADDR);
        hit_lo   = (addr == LO_ADDR);
        op       = '0;
        op.wr_hi = wr & hit_hi;
        op.wr_lo = wr & hit_lo;
        op.rd_hi = rd & ~wr & hit_hi;
        op.rd_lo = rd & ~wr & hit_lo;
    end

endmodule

// File: rtl/txpend_shadow.sv
module txpend_shadow
    import txpend_pkg::*;
#(
    parameter int BUS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  bus_op_t          op,
    input  logic [BUS_W-1:0] wdata,
    input  logic [BUS_W-1:0] live_hi,
    input  logic [BUS_W-1:0] live_lo,
    output logic [BUS_W-1:0] temp,
    output logic [BUS_W-1:0] rdata
);

    typedef struct packed {
        logic [BUS_W-1:0] temp;
        logic [BUS_W-1:0] rdata;
    } shadow_t;

    shadow_t s_d;
    shadow_t s_q;

    always_comb begin
        s_d = s_q;
        if (op.wr_hi) begin
            s_d.temp = wdata;
        end
        if (op.rd_hi) begin
            s_d.rdata = live_hi;
            s_d.temp  = live_lo;
        end
        if (op.rd_lo) begin
            s_d.rdata = s_q.temp;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign temp  = s_q.temp;
    assign rdata = s_q.rdata;

endmodule

// File: rtl/txpend_flags.sv
module txpend_flags #(
    parameter int NUM_MB   = 32,
    parameter int FIRST_MB = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [NUM_MB-1:0] set_word,
    input  logic [NUM_MB-1:0] tx_enable,
    input  logic [NUM_MB-1:0] cancel_req,
    input  logic [NUM_MB-1:0] tx_done,
    output logic [NUM_MB-1:0] pending
);

    typedef struct packed {
        logic [NUM_MB-1:0] pend;
    } flag_t;

    logic [NUM_MB-1:0] impl_mask;
    logic [NUM_MB-1:0] set_v;
    logic [NUM_MB-1:0] clr_v;
    flag_t             f_d;
    flag_t             f_q;

    // Mailboxes below FIRST_MB carry no flag at all.
    for (genvar g = 0; g < NUM_MB; g++) begin : g_mask
        assign impl_mask[g] = (g >= FIRST_MB) ? 1'b1 : 1'b0;
    end

    always_comb begin
        set_v      = commit ? (set_word & tx_enable & impl_mask) : '0;
        clr_v      = cancel_req | tx_done;
        f_d        = f_q;
        f_d.pend   = (f_q.pend | set_v) & ~clr_v & impl_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    assign pending = f_q.pend;

endmodule

// File: rtl/txpend_wordbus.sv
module txpend_wordbus
    import txpend_pkg::*;
#(
    parameter int                BUS_W   = 16,
    parameter int                ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] HI_ADDR = 8'h20,
    parameter logic [ADDR_W-1:0] LO_ADDR = 8'h22
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [BUS_W-1:0]     bus_wdata,
    output logic [BUS_W-1:0]     bus_rdata,
    input  logic [2*BUS_W-1:0]   tx_enable,
    input  logic [2*BUS_W-1:0]   cancel_req,
    input  logic [2*BUS_W-1:0]   tx_done,
    output logic [2*BUS_W-1:0]   pending
);

    localparam int NUM_MB = 2 * BUS_W;

    bus_op_t           op;
    logic [BUS_W-1:0]  temp_w;
    logic [NUM_MB-1:0] flags_w;

    txpend_decode #(
        .ADDR_W  (ADDR_W),
        .HI_ADDR (HI_ADDR),
        .LO_ADDR (LO_ADDR)
    ) u_decode (
        .addr (bus_addr),
        .wr   (bus_wr),
        .rd   (bus_rd),
        .op   (op)
    );

    txpend_shadow #(
        .BUS_W (BUS_W)
    ) u_shadow (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (op),
        .wdata   (bus_wdata),
        .live_hi (flags_w[NUM_MB-1:BUS_W]),
        .live_lo (flags_w[BUS_W-1:0]),
        .temp    (temp_w),
        .rdata   (bus_rdata)
    );

    txpend_flags #(
        .NUM_MB   (NUM_MB),
        .FIRST_MB (1)
    ) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit     (op.wr_lo),
        .set_word   ({temp_w, bus_wdata}),
        .tx_enable  (tx_enable),
        .cancel_req (cancel_req),
        .tx_done    (tx_done),
        .pending    (flags_w)
    );

    assign pending = flags_w;

endmodule

// File: rtl/txpend_chk.sv
module txpend_chk #(
    parameter int                BUS_W   = 16,
    parameter int                ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] HI_ADDR = 8'h20,
    parameter logic [ADDR_W-1:0] LO_ADDR = 8'h22
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic                 bus_wr,
    input logic                 bus_rd,
    input logic [BUS_W-1:0]     bus_wdata,
    input logic [BUS_W-1:0]     bus_rdata,
    input logic [2*BUS_W-1:0]   tx_enable,
    input logic [2*BUS_W-1:0]   cancel_req,
    input logic [2*BUS_W-1:0]   tx_done,
    input logic [2*BUS_W-1:0]   pending,
    input logic [BUS_W-1:0]     temp_val
);

    AST_BIT0_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !pending[0]); // R7

    AST_HI_WRITE_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == HI_ADDR) |=> temp_val == $past(bus_wdata)); // R2

    AST_NO_RISE_WITHOUT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == LO_ADDR) |=> (pending & ~$past(pending)) == '0); // R3

    AST_FALL_ONLY_BY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |=> ($past(pending) & ~pending & ~$past(cancel_req | tx_done)) == '0); // R4

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == LO_ADDR) |=> (pending & $past(cancel_req | tx_done)) == '0); // R6

    AST_DISABLED_NOT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |=> (pending & ~$past(pending) & ~$past(tx_enable)) == '0); // R8

    AST_HI_READ_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && bus_addr == HI_ADDR)
        |=> bus_rdata == $past(pending[2*BUS_W-1:BUS_W]) && temp_val == $past(pending[BUS_W-1:0])); // R9

    AST_LO_READ_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && bus_addr == LO_ADDR) |=> bus_rdata == $past(temp_val)); // R10

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && !bus_wr) |=> $stable(bus_rdata)); // R11

endmodule

bind txpend_wordbus txpend_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .tx_enable  (tx_enable),
    .cancel_req (cancel_req),
    .tx_done    (tx_done),
    .pending    (pending),
    .temp_val   (temp_w)
);

// File: tb/sim_txpend_wordbus.sv
`timescale 1ns/1ps
module sim_txpend_wordbus;

    localparam logic [7:0] A_HI  = 8'h20;
    localparam logic [7:0] A_LO  = 8'h22;
    localparam logic [7:0] A_BAD = 8'h24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [31:0] tx_enable = '0;
    logic [31:0] cancel_req = '0;
    logic [31:0] tx_done = '0;
    logic [31:0] pending;

    // Reference model state.
    logic [31:0] m_pend = '0;
    logic [15:0] m_temp = '0;
    logic [15:0] m_rdata = '0;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    finished = 0;
    string cur_req = "R1";
    logic [31:0] rng = 32'h1234_5678;

    always #2.5 clk = ~clk;

    txpend_wordbus u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .tx_enable  (tx_enable),
        .cancel_req (cancel_req),
        .tx_done    (tx_done),
        .pending    (pending)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] next_rng(input logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    // One bus cycle: drive, let the edge pass, update the model, compare.
    task automatic cycle(input logic [7:0] a, input logic w, input logic r,
                         input logic [15:0] d, input logic [31:0] can, input logic [31:0] dn);
        logic [31:0] nxt;
        bus_addr = a; bus_wr = w; bus_rd = r; bus_wdata = d;
        cancel_req = can; tx_done = dn;
        @(posedge clk);
        nxt = m_pend;
        if (w && a == A_LO) nxt = nxt | ({m_temp, d} & tx_enable & 32'hFFFF_FFFE);
        nxt = nxt & ~(can | dn);
        if (!w && r && a == A_HI) begin
            m_rdata = m_pend[31:16];
            m_temp  = m_pend[15:0];
        end else if (!w && r && a == A_LO) begin
            m_rdata = m_temp;
        end
        if (w && a == A_HI) m_temp = d;
        m_pend = nxt;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0; cancel_req = '0; tx_done = '0;
        check({cur_req, " pending"}, pending, m_pend);
        check({cur_req, " rdata"}, {16'h0, bus_rdata}, {16'h0, m_rdata});
    endtask

    task automatic idle();
        cycle(A_BAD, 1'b0, 1'b0, 16'h0, '0, '0);
    endtask

    task automatic write32(input logic [31:0] v);
        cycle(A_HI, 1'b1, 1'b0, v[31:16], '0, '0);
        cycle(A_LO, 1'b1, 1'b0, v[15:0], '0, '0);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        cur_req = "R1";
        check("R1 reset pending", pending, 32'h0);
        check("R1 reset rdata", {16'h0, bus_rdata}, 32'h0);
        rst_n = 1'b1;
        tx_enable = 32'hFFFF_FFFF;
        cycle(A_LO, 1'b0, 1'b1, 16'h0, '0, '0);   // R1 shadow reset
        check("R1 shadow after reset", {16'h0, bus_rdata}, 32'h0);

        cur_req = "R2";
        cycle(A_HI, 1'b1, 1'b0, 16'hFFFF, '0, '0);
        idle(); idle();
        check("R2 upper write parked", pending, 32'h0);

        cur_req = "R3";
        cycle(A_LO, 1'b1, 1'b0, 16'h00F0, '0, '0);
        check("R3 both halves commit", pending, 32'hFFFF_00F0);

        cur_req = "R4";
        write32(32'h0000_0000);
        check("R4 zero write no effect", pending, 32'hFFFF_00F0);

        cur_req = "R5";
        cycle(A_BAD, 1'b0, 1'b0, 16'h0, 32'h0000_0010, '0);
        cycle(A_BAD, 1'b0, 1'b0, 16'h0, '0, 32'h8000_0000);
        check("R5 cancel and done clear", pending, 32'h7FFF_00E0);

        cur_req = "R6";
        cycle(A_HI, 1'b1, 1'b0, 16'h8000, '0, '0);
        cycle(A_LO, 1'b1, 1'b0, 16'h0006, 32'h0000_0002, 32'h8000_0000);
        check("R6 clear wins", pending, 32'h7FFF_00E4);

        cur_req = "R7";
        write32(32'h0000_0001);
        check("R7 bit0 empty", {31'h0, pending[0]}, 32'h0);

        cur_req = "R8";
        cycle(A_BAD, 1'b0, 1'b0, 16'h0, 32'hFFFF_FFFF, '0);
        tx_enable = 32'h00FF_FF00;
        write32(32'hFFFF_FFFF);
        check("R8 disabled ignored", pending, 32'h00FF_FF00);

        cur_req = "R9";
        cycle(A_HI, 1'b0, 1'b1, 16'h0, '0, '0);
        check("R9 upper read live", {16'h0, bus_rdata}, 32'h0000_00FF);
        cur_req = "R10";
        cycle(A_BAD, 1'b0, 1'b0, 16'h0, 32'h0000_FF00, '0);
        cycle(A_LO, 1'b0, 1'b1, 16'h0, '0, '0);
        check("R10 lower read snapshot", {16'h0, bus_rdata}, 32'h0000_FF00);
        idle();
        check("R10 rdata held", {16'h0, bus_rdata}, 32'h0000_FF00);

        cur_req = "R11";
        tx_enable = 32'hFFFF_FFFF;
        cycle(A_HI, 1'b1, 1'b0, 16'h0F00, '0, '0);
        cycle(A_BAD, 1'b1, 1'b1, 16'hFFFF, '0, '0);
        cycle(A_LO, 1'b1, 1'b1, 16'h0300, '0, '0);
        check("R11 stray addr and wr-over-rd", pending, 32'h0FFF_0300);
        check("R11 rdata unchanged", {16'h0, bus_rdata}, 32'h0000_FF00);

        cur_req = "R3 random";
        tx_enable = 32'hF0F0_3C3D;
        for (int i = 0; i < 400; i++) begin
            logic [7:0] a;
            rng = next_rng(rng);
            case (rng[1:0])
                2'd0: a = A_HI;
                2'd1: a = A_LO;
                2'd2: a = A_LO;
                default: a = A_BAD;
            endcase
            cycle(a, rng[2], rng[3], rng[31:16],
                  (rng[6:4] == 3'd0) ? next_rng(rng) : 32'h0,
                  (rng[9:7] == 3'd0) ? ~rng : 32'h0);
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule